// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block decides, every cycle, whether a five-stage in-order pipeline that has no operand bypass network must stall. It looks at the instruction sitting in decode (its opcode and its three register fields) and at the opcode and destination register of the instructions in execute, memory and writeback. If decode wants to read a register that an older instruction will still write, the front of the pipe (fetch and decode) is held and an all-zero NOP is pushed into execute in place of the decode instruction. This repeats until the producing instruction has left the compared stages.

The controller also handles a failed data-memory read. In that cycle every stage up to memory keeps its contents and writeback receives a NOP. A static mode input tells the block whether the register file writes early in the cycle and reads late. In that mode an instruction in writeback has already delivered its result, so writeback takes no part in the comparison.

The decisions are purely combinational from the current stage contents. The hold and bubble strobes therefore act on the very clock edge that follows the detection. The block also reports which stage holds the nearest conflicting producer.

Top module: `hazInterlock`

## Requirements
- R1: Opcodes are 3-bit codes: NOP=0, ADD=1, SUB=2, LOAD=3, STORE=4, BR=5, BREQ=6, BRNEQ=7. Only ADD, SUB and LOAD in execute, memory or writeback can cause a stall. Any other opcode in those stages never does, whatever its destination field holds.
- R2: When the decode instruction is not a NOP and its src1 or src2 field equals the destination of a producer in execute or memory, holdFront and bubbleEx are both 1 and holdBack and bubbleWb are 0 (with readFail low).
- R3: For STORE, BR, BREQ and BRNEQ in decode, the dst field is compared as well, as a third source. For ADD, SUB and LOAD in decode, the dst field is never compared.
- R4: With splitRf=0 a producer in writeback is compared like the other stages. With splitRf=1 writeback is excluded and never causes a stall.
- R5: hazWhere reports the nearest conflicting producer: 0 = none, 1 = execute, 2 = memory, 3 = writeback. The search starts at execute and the first match wins.
- R6: When readFail is 1, holdFront, holdBack and bubbleWb are 1 and bubbleEx is 0, whether or not a register conflict exists. hazWhere still reports the conflict.
- R7: A NOP in decode never stalls, whatever its register fields contain.
- R8: With no conflict and readFail low, all four strobes and hazWhere are 0. This includes the reset state with every stage holding a NOP.
- R9: The strobes follow the stage contents within the same cycle. As a producer moves from execute to memory to writeback, the stall lasts three cycles with splitRf=0 and two cycles with splitRf=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded property checks |
| rstN | input | 1 | Active-low reset, disables the property checks |
| splitRf | input | 1 | 1 = register file writes before it reads, so writeback is not compared |
| readFail | input | 1 | Data-memory read failed this cycle |
| decOp | input | 3 | Opcode of the instruction in decode |
| decSrc1 | input | REG_W | First source register field in decode |
| decSrc2 | input | REG_W | Second source register field in decode |
| decDst | input | REG_W | Destination field in decode (read by stores and branches) |
| exOp | input | 3 | Opcode in execute |
| exDst | input | REG_W | Destination field in execute |
| memOp | input | 3 | Opcode in memory |
| memDst | input | REG_W | Destination field in memory |
| wbOp | input | 3 | Opcode in writeback |
| wbDst | input | REG_W | Destination field in writeback |
| holdFront | output | 1 | Hold fetch and decode |
| holdBack | output | 1 | Hold execute and memory |
| bubbleEx | output | 1 | Load a cleared NOP into execute |
| bubbleWb | output | 1 | Load a cleared NOP into writeback |
| hazWhere | output | 2 | Stage of the nearest conflicting producer (0 none, 1 EX, 2 MEM, 3 WB) |

## Verification
Directed patterns place a single producer in each of execute, memory and writeback in turn. They match it against src1, src2 and the dst field, which separates a missing comparator from a wrongly enabled one. Non-producer opcodes carrying a matching destination, and a NOP in decode with matching fields, show that the opcode qualifies every comparison. Stacked matches in several stages check that the search order is nearest first. The same writeback match under both register-file modes checks the stage exclusion. A producer walked down the pipe cycle by cycle checks the stall length, and read failures with and without a conflict check that the freeze overrides the bubble.

// File: rtl/hazPkg.sv
package hazPkg;

  // producer stages compared against decode: execute, memory, writeback
  localparam int PROD_STAGES = 3;
  localparam int WHERE_W     = $clog2(PROD_STAGES + 1);
  localparam int OP_W        = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4,
    OP_BR    = 3'd5,
    OP_BREQ  = 3'd6,
    OP_BRNEQ = 3'd7
  } opcode_e;

  // strobes from control to the comparator datapath
  typedef struct packed {
    logic                   chkSrc;   // compare src1/src2
    logic                   chkDst;   // compare dst field as a source
    logic [PROD_STAGES-1:0] stageEn;  // which producer stages take part
  } cmpStrobe_t;

  function automatic logic writesReg(logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_LOAD);
  endfunction

  function automatic logic readsDstField(logic [OP_W-1:0] op);
    return (op == OP_STORE) || (op == OP_BR) || (op == OP_BREQ) || (op == OP_BRNEQ);
  endfunction

endpackage

// File: rtl/hazCompare.sv
module hazCompare
  import hazPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]                  decSrc1,
  input  logic [REG_W-1:0]                  decSrc2,
  input  logic [REG_W-1:0]                  decDst,
  input  logic [PROD_STAGES-1:0][OP_W-1:0]  prodOp,
  input  logic [PROD_STAGES-1:0][REG_W-1:0] prodDst,
  input  cmpStrobe_t                        strobe,
  output logic [PROD_STAGES-1:0]            matchVec
);

  // one comparator slice per producer stage
  for (genvar g = 0; g < PROD_STAGES; g++) begin : gSlice
    logic live;
    logic srcHit;
    logic dstHit;

    assign live   = strobe.stageEn[g] && writesReg(prodOp[g]);
    assign srcHit = strobe.chkSrc &&
                    ((decSrc1 == prodDst[g]) || (decSrc2 == prodDst[g]));
    assign dstHit = strobe.chkDst && (decDst == prodDst[g]);
    assign matchVec[g] = live && (srcHit || dstHit);
  end

endmodule

// File: rtl/hazControl.sv
module hazControl
  import hazPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [OP_W-1:0]        decOp,
  input  logic                   splitRf,
  input  logic                   readFail,
  input  logic [PROD_STAGES-1:0] matchVec,
  output cmpStrobe_t             strobe,
  output logic                   holdFront,
  output logic                   holdBack,
  output logic                   bubbleEx,
  output logic                   bubbleWb,
  output logic [WHERE_W-1:0]     hazWhere
);

  logic conflict;

  // decode class and stage enables for the comparator slices
  always_comb begin
    strobe.chkSrc  = (decOp != OP_NOP);
    strobe.chkDst  = readsDstField(decOp);
    strobe.stageEn = '1;
    strobe.stageEn[PROD_STAGES-1] = !splitRf;
  end

  // nearest producer wins: scan from the far end so the lowest index is kept
  always_comb begin
    hazWhere = '0;
    for (int i = PROD_STAGES - 1; i >= 0; i--) begin
      if (matchVec[i]) hazWhere = WHERE_W'(i + 1);
    end
  end

  assign conflict = |matchVec;

  always_comb begin
    if (readFail) begin
      holdFront = 1'b1;
      holdBack  = 1'b1;
      bubbleEx  = 1'b0;
      bubbleWb  = 1'b1;
    end else begin
      holdFront = conflict;
      holdBack  = 1'b0;
      bubbleEx  = conflict;
      bubbleWb  = 1'b0;
    end
  end

  // R6
  freeze_on_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    readFail |-> (holdFront && holdBack && bubbleWb && !bubbleEx));

  // R2
  stall_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readFail && (matchVec != '0)) |-> (holdFront && bubbleEx && !holdBack && !bubbleWb));

  // R5
  where_mem_nearest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hazWhere == WHERE_W'(2)) |-> (matchVec[1] && !matchVec[0]));

  // R5
  where_wb_nearest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hazWhere == WHERE_W'(3)) |-> (matchVec[2] && !matchVec[1] && !matchVec[0]));

endmodule

// File: rtl/hazInterlock.sv
module hazInterlock
  import hazPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               splitRf,
  input  logic               readFail,
  input  logic [2:0]         decOp,
  input  logic [REG_W-1:0]   decSrc1,
  input  logic [REG_W-1:0]   decSrc2,
  input  logic [REG_W-1:0]   decDst,
  input  logic [2:0]         exOp,
  input  logic [REG_W-1:0]   exDst,
  input  logic [2:0]         memOp,
  input  logic [REG_W-1:0]   memDst,
  input  logic [2:0]         wbOp,
  input  logic [REG_W-1:0]   wbDst,
  output logic               holdFront,
  output logic               holdBack,
  output logic               bubbleEx,
  output logic               bubbleWb,
  output logic [1:0]         hazWhere
);

  logic [PROD_STAGES-1:0][OP_W-1:0]  prodOp;
  logic [PROD_STAGES-1:0][REG_W-1:0] prodDst;
  logic [PROD_STAGES-1:0]            matchVec;
  cmpStrobe_t                        strobe;

  // index order is the search order: execute nearest
  assign prodOp  = {wbOp, memOp, exOp};
  assign prodDst = {wbDst, memDst, exDst};

  hazCompare #(.REG_W(REG_W)) uCompare (
    .decSrc1  (decSrc1),
    .decSrc2  (decSrc2),
    .decDst   (decDst),
    .prodOp   (prodOp),
    .prodDst  (prodDst),
    .strobe   (strobe),
    .matchVec (matchVec)
  );

  hazControl uControl (
    .clk       (clk),
    .rstN      (rstN),
    .decOp     (decOp),
    .splitRf   (splitRf),
    .readFail  (readFail),
    .matchVec  (matchVec),
    .strobe    (strobe),
    .holdFront (holdFront),
    .holdBack  (holdBack),
    .bubbleEx  (bubbleEx),
    .bubbleWb  (bubbleWb),
    .hazWhere  (hazWhere)
  );

  // R1
  no_producer_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!writesReg(exOp) && !writesReg(memOp) && (splitRf || !writesReg(wbOp)))
      |-> (hazWhere == 2'd0));

  // R7
  nop_decode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decOp == 3'd0) |-> (hazWhere == 2'd0));

  // R4
  split_skips_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    splitRf |-> (hazWhere != 2'd3));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readFail && (hazWhere == 2'd0)) |-> !(holdFront || holdBack || bubbleEx || bubbleWb));

endmodule

// File: tb/test_hazInterlock.sv
`timescale 1ns/1ps
module test_hazInterlock;

  localparam int RW = 5;
  localparam logic [2:0] NOP = 3'd0, ADD = 3'd1, SUB = 3'd2, LD = 3'd3,
                         ST = 3'd4, BR = 3'd5, BEQ = 3'd6, BNE = 3'd7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic splitRf = 1'b0, readFail = 1'b0;
  logic [2:0] decOp = NOP, exOp = NOP, memOp = NOP, wbOp = NOP;
  logic [RW-1:0] decSrc1 = '0, decSrc2 = '0, decDst = '0;
  logic [RW-1:0] exDst = '0, memDst = '0, wbDst = '0;
  logic holdFront, holdBack, bubbleEx, bubbleWb;
  logic [1:0] hazWhere;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  hazInterlock #(.REG_W(RW)) i_hazInterlock (
    .clk(clk), .rstN(rstN), .splitRf(splitRf), .readFail(readFail),
    .decOp(decOp), .decSrc1(decSrc1), .decSrc2(decSrc2), .decDst(decDst),
    .exOp(exOp), .exDst(exDst), .memOp(memOp), .memDst(memDst),
    .wbOp(wbOp), .wbDst(wbDst),
    .holdFront(holdFront), .holdBack(holdBack), .bubbleEx(bubbleEx),
    .bubbleWb(bubbleWb), .hazWhere(hazWhere)
  );

  task automatic setPipe(input logic [2:0] dOp, input int s1, input int s2, input int d,
                         input logic [2:0] xOp, input int xD,
                         input logic [2:0] mOp, input int mD,
                         input logic [2:0] wOp, input int wD);
    @(negedge clk);
    decOp = dOp; decSrc1 = RW'(s1); decSrc2 = RW'(s2); decDst = RW'(d);
    exOp = xOp; exDst = RW'(xD);
    memOp = mOp; memDst = RW'(mD);
    wbOp = wOp; wbDst = RW'(wD);
    #1;
  endtask

  // expected {holdFront, holdBack, bubbleEx, bubbleWb, hazWhere}
  task automatic expect6(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {holdFront, holdBack, bubbleEx, bubbleWb, hazWhere};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tReset();
    setPipe(NOP, 0, 0, 0, NOP, 0, NOP, 0, NOP, 0);
    expect6("R8 reset idle", 6'b0000_00);
    @(negedge clk); rstN = 1'b1;
    setPipe(ADD, 1, 2, 9, SUB, 3, LD, 4, ADD, 5);
    expect6("R8 no register overlap", 6'b0000_00);
  endtask

  task automatic tSourceMatch();
    setPipe(ADD, 3, 1, 0, ADD, 3, NOP, 0, NOP, 0);
    expect6("R2 src1 vs execute", 6'b1010_01);
    setPipe(SUB, 1, 6, 0, NOP, 0, SUB, 6, NOP, 0);
    expect6("R2 src2 vs memory", 6'b1010_10);
    setPipe(LD, 7, 2, 0, LD, 7, NOP, 0, NOP, 0);
    expect6("R1 load in execute is a producer", 6'b1010_01);
  endtask

  task automatic tNonProducers();
    setPipe(ADD, 3, 3, 0, ST, 3, BR, 3, BEQ, 3);
    expect6("R1 store/branch stages never stall", 6'b0000_00);
    setPipe(ADD, 4, 4, 0, NOP, 4, BNE, 4, NOP, 4);
    expect6("R1 nop/brneq stages never stall", 6'b0000_00);
  endtask

  task automatic tDstField();
    setPipe(ST, 1, 2, 5, ADD, 5, NOP, 0, NOP, 0);
    expect6("R3 store dst vs execute", 6'b1010_01);
    setPipe(ADD, 1, 2, 5, ADD, 5, NOP, 0, NOP, 0);
    expect6("R3 add dst not compared", 6'b0000_00);
    setPipe(BEQ, 1, 2, 7, NOP, 0, LD, 7, NOP, 0);
    expect6("R3 breq dst vs memory", 6'b1010_10);
    setPipe(BR, 0, 0, 9, NOP, 0, NOP, 0, SUB, 9);
    expect6("R3 br dst vs writeback", 6'b1010_11);
    setPipe(LD, 1, 2, 8, NOP, 0, LD, 8, NOP, 0);
    expect6("R3 load dst not compared", 6'b0000_00);
  endtask

  task automatic tSplit();
    splitRf = 1'b0;
    setPipe(ADD, 4, 1, 0, NOP, 0, NOP, 0, ADD, 4);
    expect6("R4 writeback compared when not split", 6'b1010_11);
    splitRf = 1'b1;
    setPipe(ADD, 4, 1, 0, NOP, 0, NOP, 0, ADD, 4);
    expect6("R4 writeback excluded when split", 6'b0000_00);
    setPipe(ADD, 4, 1, 0, NOP, 0, ADD, 4, ADD, 4);
    expect6("R4 memory still compared when split", 6'b1010_10);
    splitRf = 1'b0;
  endtask

  task automatic tPriority();
    setPipe(ADD, 2, 2, 0, ADD, 2, SUB, 2, LD, 2);
    expect6("R5 all stages match, execute wins", 6'b1010_01);
    setPipe(ADD, 2, 3, 0, ADD, 9, SUB, 3, LD, 2);
    expect6("R5 memory nearer than writeback", 6'b1010_10);
    setPipe(ST, 1, 1, 6, ST, 6, BR, 6, ADD, 6);
    expect6("R5 non-producers skipped in search", 6'b1010_11);
  endtask

  task automatic tReadFail();
    readFail = 1'b1;
    setPipe(ADD, 1, 2, 0, NOP, 0, NOP, 0, NOP, 0);
    expect6("R6 read fail without conflict", 6'b1101_00);
    setPipe(ADD, 5, 2, 0, NOP, 0, LD, 5, NOP, 0);
    expect6("R6 read fail overrides bubble", 6'b1101_10);
    readFail = 1'b0;
    setPipe(ADD, 5, 2, 0, NOP, 0, LD, 5, NOP, 0);
    expect6("R6 back to bubble after fail clears", 6'b1010_10);
  endtask

  task automatic tNopDecode();
    setPipe(NOP, 3, 3, 3, ADD, 3, SUB, 3, LD, 3);
    expect6("R7 nop in decode with matching fields", 6'b0000_00);
  endtask

  task automatic tWalk(input logic split, input string tag);
    splitRf = split;
    setPipe(SUB, 12, 1, 0, ADD, 12, NOP, 0, NOP, 0);
    expect6({"R9 ", tag, " producer in execute"}, 6'b1010_01);
    setPipe(SUB, 12, 1, 0, NOP, 0, ADD, 12, NOP, 0);
    expect6({"R9 ", tag, " producer in memory"}, 6'b1010_10);
    setPipe(SUB, 12, 1, 0, NOP, 0, NOP, 0, ADD, 12);
    if (split) expect6({"R9 ", tag, " released at writeback"}, 6'b0000_00);
    else       expect6({"R9 ", tag, " producer in writeback"}, 6'b1010_11);
    setPipe(SUB, 12, 1, 0, NOP, 0, NOP, 0, NOP, 0);
    expect6({"R9 ", tag, " producer retired"}, 6'b0000_00);
    splitRf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tReset();
    tSourceMatch();
    tNonProducers();
    tDstField();
    tSplit();
    tPriority();
    tReadFail();
    tNopDecode();
    tWalk(1'b0, "unified");
    tWalk(1'b1, "split");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule